// File: doc/BRIEF.md
# Cascadable Synchronous Presettable Binary Counter

This block is a synchronous up-counter built from a chain of 4-bit modulo-16 stages joined by carry lookahead. Every change of state happens on the rising clock edge. An active-low clear empties the whole counter. An active-low load copies a parallel data word into every stage on the same edge. Counting needs two enables to be high together: a parallel enable and a trickle enable.

The carry output goes high when the counter holds its all-ones value and the trickle enable is high. This lets a further counter be chained onto this one without extra gates.

Inside the block, the first stage's terminal count is ANDed once with the parallel enable. That signal is fanned out to the parallel enable of every higher stage. The trickle enable of each higher stage comes from the terminal count of the stage just below it. Because of this, the carry never waits for a ripple through all the stages before the next edge.

The mode priority is fixed, from highest to lowest: clear, load, count, hold.

Top module: `cascade_counter`

## Requirements
- R1: The count runs through 0 to 16^STAGES−1 in binary. On the next counting edge it wraps from all ones to zero.
- R2: When clr_n is low at a rising edge, count becomes zero, whatever the values of ld_n, the enables and din.
- R3: When clr_n is high and ld_n is low at a rising edge, count takes the value of din in all stages at once, whatever the values of the enables.
- R4: When clr_n and ld_n are high and en_par and en_trk are both high, count increases by exactly one at the rising edge. This includes the edges where a carry crosses from one 4-bit stage into the next (for example 0x0F to 0x10).
- R5: When clr_n and ld_n are high and either en_par or en_trk is low, count keeps its value at the rising edge.
- R6: carry is combinational. It is high exactly when en_trk is high and count is all ones. It does not depend on en_par, ld_n or clr_n.
- R7: When clr_n and ld_n are both low, clear wins and count becomes zero.
- R8: Loading all ones with both enables high gives all ones on that edge, not all ones plus one. The next counting edge then wraps to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clr_n | input | 1 | Synchronous clear, active low |
| ld_n | input | 1 | Synchronous parallel load, active low |
| en_par | input | 1 | Parallel count enable |
| en_trk | input | 1 | Trickle count enable; also gates carry |
| din | input | 4*STAGES | Parallel load data |
| count | output | 4*STAGES | Counter value |
| carry | output | 1 | High when en_trk is high and count is all ones |

## Verification
The bench goes after the points where the stages meet and the points where modes compete.

- Nibble rollover (0x0F to 0x10) and the full wrap from 0xFF: a design with broken lookahead would bump a high stage too early or leave it stuck.
- Clear against load, and load against count: a design with the wrong priority would load when it should clear, or load and increment on the same edge.
- The carry with only en_par low, and with ld_n low: a design that folds those controls into the carry would drop it at the wrong time.
- One enable low while the other is high: a design that ORs the enables would count when it should hold.

// File: rtl/cnt4_stage.sv
module cnt4_stage (
  input  logic       clk,
  input  logic       clr_n,
  input  logic       ld_n,
  input  logic       enp,
  input  logic       ent,
  input  logic [3:0] d,
  output logic [3:0] q,
  output logic       tc
);
  always_ff @(posedge clk) begin
    if (!clr_n)          q <= 4'd0;
    else if (!ld_n)      q <= d;
    else if (enp && ent) q <= q + 4'd1;
  end

  assign tc = ent & (&q);

  logic armed = 1'b0;
  always_ff @(posedge clk) if (!clr_n || !ld_n) armed <= 1'b1;

  AST_STAGE_TC_NEEDS_ENT: assert property (@(posedge clk) disable iff (!armed) tc |-> ent); // R6
  AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && ld_n && !ent) |=> $stable(q)); // R5
endmodule

// File: rtl/cascade_counter.sv
module cascade_counter #(
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              ld_n,
  input  logic              en_par,
  input  logic              en_trk,
  input  logic [4*STAGES-1:0] din,
  output logic [4*STAGES-1:0] count,
  output logic              carry
);
  localparam int W = 4 * STAGES;

  logic [STAGES-1:0] tcv;
  logic              look;

  assign look = tcv[0] & en_par;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    logic enp_k, ent_k;
    if (k == 0) begin : g_first
      assign enp_k = en_par;
      assign ent_k = en_trk;
    end else begin : g_next
      assign enp_k = look;
      assign ent_k = tcv[k-1];
    end
    cnt4_stage u_stage (
      .clk  (clk),
      .clr_n(clr_n),
      .ld_n (ld_n),
      .enp  (enp_k),
      .ent  (ent_k),
      .d    (din[4*k +: 4]),
      .q    (count[4*k +: 4]),
      .tc   (tcv[k])
    );
  end

  assign carry = tcv[STAGES-1];

  logic armed = 1'b0;
  always_ff @(posedge clk) if (!clr_n || !ld_n) armed <= 1'b1;

  AST_CLEAR_ZERO: assert property (@(posedge clk) !clr_n |=> count == '0); // R2
  AST_LOAD_DATA: assert property (@(posedge clk) (clr_n && !ld_n) |=> count == $past(din)); // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && ld_n && en_par && en_trk) |=> count == W'($past(count) + 1'b1)); // R4
  AST_HOLD_VALUE: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && ld_n && !(en_par && en_trk)) |=> $stable(count)); // R5
  AST_CARRY_MATCH: assert property (@(posedge clk) disable iff (!armed)
    carry == (en_trk && (count == {W{1'b1}}))); // R6
endmodule

// File: tb/tb_cascade_counter.sv
module tb_cascade_counter;
  localparam int STAGES = 2;
  localparam int W = 4 * STAGES;
  localparam logic [W-1:0] ONES = {W{1'b1}};

  logic clk = 1'b0;
  logic clr_n = 1'b1, ld_n = 1'b1, en_par = 1'b0, en_trk = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] count;
  logic carry;
  logic [W-1:0] exp_q = '0;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  cascade_counter #(.STAGES(STAGES)) dut (
    .clk(clk), .clr_n(clr_n), .ld_n(ld_n), .en_par(en_par), .en_trk(en_trk),
    .din(din), .count(count), .carry(carry));

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  task automatic tick(input string tag);
    if (!clr_n)                exp_q = '0;
    else if (!ld_n)            exp_q = din;
    else if (en_par && en_trk) exp_q = exp_q + 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(tag, count, exp_q);
    chk({tag, " carry R6"}, W'(carry), W'(en_trk && exp_q == ONES));
  endtask

  task automatic set(input logic c, input logic l, input logic p, input logic t, input logic [W-1:0] d);
    clr_n = c; ld_n = l; en_par = p; en_trk = t; din = d;
  endtask

  task automatic t_reset;
    set(0, 1, 1, 1, 8'h5A); tick("R2 clear from power-up");
    set(0, 1, 1, 1, 8'h33); tick("R2 clear holds zero");
  endtask

  task automatic t_count_seq;
    set(1, 1, 1, 1, '0);
    for (int i = 0; i < 20; i++) tick("R4 count sequence");
  endtask

  task automatic t_stage_cross;
    set(1, 0, 0, 0, 8'h0E); tick("R3 load 0E");
    set(1, 1, 1, 1, '0); tick("R4 0E to 0F"); tick("R4 cross 0F to 10"); tick("R4 10 to 11");
  endtask

  task automatic t_hold;
    set(1, 0, 1, 0, 8'h4F); tick("R3 load ignores enables");
    set(1, 1, 0, 1, '0); tick("R5 hold en_par low"); tick("R5 hold en_par low 2");
    set(1, 1, 1, 0, '0); tick("R5 hold en_trk low");
    set(1, 1, 0, 0, '0); tick("R5 hold both low");
  endtask

  task automatic t_wrap;
    set(1, 0, 1, 1, ONES); tick("R8 load all ones with enables");
    set(1, 1, 1, 1, '0); tick("R1 wrap to zero");
    set(1, 0, 1, 1, 8'hFE); tick("R3 load FE");
    set(1, 1, 1, 1, '0); tick("R1 FE to FF"); tick("R1 FF wraps");
  endtask

  task automatic t_carry_indep;
    set(1, 0, 0, 1, ONES); tick("R3 load FF");
    set(1, 1, 0, 1, '0); #1;
    chk("R6 carry with en_par low", W'(carry), W'(1));
    ld_n = 0; din = 8'h12; #1;
    chk("R6 carry with ld_n low", W'(carry), W'(1));
    clr_n = 0; #1;
    chk("R6 carry with clr_n low", W'(carry), W'(1));
    en_trk = 0; #1;
    chk("R6 carry drops with en_trk", W'(carry), W'(0));
    set(1, 1, 0, 1, '0); tick("R5 hold at FF");
  endtask

  task automatic t_priority;
    set(1, 0, 1, 1, 8'hC3); tick("R3 load C3");
    set(0, 0, 1, 1, 8'h77); tick("R7 clear beats load");
    set(1, 0, 1, 1, 8'h81); tick("R3 load beats count");
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_count_seq();
    t_stage_cross();
    t_hold();
    t_wrap();
    t_carry_indep();
    t_priority();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule